// File: doc/BRIEF.md
# Supply Rail Start-Up Sequencer

This controller takes a board from standby to a running state once mains power is present. It first powers the low-voltage core rail. It then switches on the main rails by pulling two active-low mode lines low, and the main processor leaves reset at the same moment. After a settling delay it samples the power-good detect inputs on a coarse, regular grid of millisecond ticks. A rail counts as present only when its detect has made a low-to-high transition since the mode lines went low, and that transition has been seen at one of the sampling points.

Each watched rail has its own deadline, counted from the mode-line toggle. A missed 5 V or 12 V deadline stops the sequence in a protection state and leaves a rail-specific fault code. A missed 8.6 V deadline is only flagged, and start-up carries on. Once the 5 V, 12 V and core rails are confirmed, the memory power-reset line is released. After a short initialisation delay the controller raises its ready output. An external protection request stops the sequence while start-up is under way, and has no effect after ready.

All timing is counted in pulses of a single-cycle millisecond tick input, so the block runs from any fast clock. Every asynchronous input passes through a two-flop synchronizer.

Top module: `rail_bringup_seq`

## Requirements
- R1: During and right after reset: cpu_rst=1, audio_en=1, audio_rst=1, mem_pwr=1, mode_a_n=1, mode_b_n=1, core_en=0, ready=0, prot_stop=0, err_8v6=0, fault_code=0.
- R2: After mains_ok is seen high, core_en goes high. On the next tick both mode lines go low and cpu_rst goes low in the same cycle. core_en is already high at that point.
- R3: Tick count t starts at 0 when the mode lines go low. Detects are sampled only on the ticks where t = 50 + 40k. A detect that rises between two such ticks takes effect at the next one, and the sequence advances on that tick without waiting for any deadline.
- R4: A detect counts only after a low-to-high transition that follows the mode-line toggle. A detect that is already high before the toggle and stays high never counts.
- R5: If the 5 V rail is unconfirmed when t reaches 2900, the block enters protection with fault_code=1. Otherwise, if the 12 V rail is unconfirmed at t=2900, fault_code=2. The fault code then holds.
- R6: If the 8.6 V rail is unconfirmed when t reaches 6300, err_8v6 goes high and stays high. fault_code becomes 3 if it was 0. The sequence and ready are unaffected.
- R7: When 5 V, 12 V and core are all confirmed, mem_pwr goes low. Two ticks later ready goes high. Without a confirmed core rail, mem_pwr stays high and ready stays low.
- R8: prot_in seen high between leaving idle and ready puts the block in protection with fault_code unchanged (0 unless the 8.6 V flag set 3). prot_in has no effect while ready is high.
- R9: In protection, prot_stop=1, both mode lines are high, core_en=0, cpu_rst=1, audio_en=0, audio_rst=0, mem_pwr=1, and ready=0. Only a reset leaves this state.
- R10: Timing advances only on cycles with tick_ms high, so the same tick sequence gives the same behaviour whatever the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| mains_ok | input | 1 | Mains present, starts the sequence (asynchronous) |
| det_5v | input | 1 | 5 V power-good detect (asynchronous) |
| det_8v6 | input | 1 | 8.6 V power-good detect (asynchronous) |
| det_12v | input | 1 | 12 V power-good detect (asynchronous) |
| det_core | input | 1 | Core rail power-good detect (asynchronous) |
| prot_in | input | 1 | External protection request (asynchronous) |
| core_en | output | 1 | Core rail enable, high = on |
| mode_a_n | output | 1 | First main-rail mode line, low = rails on |
| mode_b_n | output | 1 | Second main-rail mode line, low = rails on |
| cpu_rst | output | 1 | Main processor reset, high = held |
| audio_en | output | 1 | Audio enable line |
| audio_rst | output | 1 | Audio reset line |
| mem_pwr | output | 1 | Memory power-reset line, low = released |
| ready | output | 1 | Start-up finished, memory usable |
| prot_stop | output | 1 | Protection state entered |
| err_8v6 | output | 1 | Sticky flag: 8.6 V deadline missed |
| fault_code | output | 2 | 0 none, 1 5 V, 2 12 V, 3 8.6 V flag only |

## Verification
The bench targets polling granularity. A detect that rises just after a sample point must not advance the sequence until the following one, and a design that watched the detects continuously would release memory about 30 ticks early. A 5 V detect held high through the toggle must still lead to the 5 V fault at tick 2900, which catches a design that checks levels instead of edges. The 8.6 V miss is run past ready to show that it changes only the flag and the code. Protection requests are placed both inside start-up and after ready, to expose a design that ignores them at the wrong time or leaves the protection state on its own.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CORE,
        ST_RAMP,
        ST_MEMW,
        ST_RUN,
        ST_PROT
    } seq_st_e;

    localparam logic [1:0] FLT_NONE = 2'd0;
    localparam logic [1:0] FLT_5V   = 2'd1;
    localparam logic [1:0] FLT_12V  = 2'd2;
    localparam logic [1:0] FLT_8V6  = 2'd3;

    localparam int RAIL_5V   = 0;
    localparam int RAIL_12V  = 1;
    localparam int RAIL_8V6  = 2;
    localparam int RAIL_CORE = 3;
    localparam int NUM_RAILS = 4;

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rs_poll_timer.sv
// Counts ticks since the main rails were switched on and marks sample points.
module rs_poll_timer #(
    parameter int SETTLE_MS = 50,
    parameter int POLL_MS   = 40,
    parameter int CAP_MS    = 6300,
    parameter int TW        = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    output logic          step_o,
    output logic [TW-1:0] ms_next_o,
    output logic          poll_o
);
    localparam int PW = (POLL_MS > 1) ? $clog2(POLL_MS) : 1;
    localparam logic [TW-1:0] SETTLE_T = TW'(SETTLE_MS);
    localparam logic [TW-1:0] CAP_T    = TW'(CAP_MS);
    localparam logic [PW-1:0] LAST_PH  = PW'(POLL_MS - 1);

    typedef struct packed {
        logic [TW-1:0] ms;
        logic [PW-1:0] ph;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        step_o    = tick_i & run_i & (r_q.ms < CAP_T);
        ms_next_o = r_q.ms + TW'(1);
        poll_o    = 1'b0;
        if (!run_i) begin
            r_d.ms = '0;
            r_d.ph = '0;
        end else if (step_o) begin
            r_d.ms = ms_next_o;
            if (ms_next_o == SETTLE_T) begin
                poll_o = 1'b1;
                r_d.ph = '0;
            end else if (ms_next_o > SETTLE_T) begin
                if (r_q.ph == LAST_PH) begin
                    poll_o = 1'b1;
                    r_d.ph = '0;
                end else begin
                    r_d.ph = r_q.ph + PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/rs_rail_watch.sv
// Per-rail edge capture; a rail is confirmed at the first sample after a rise.
module rs_rail_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic lvl_i,
    input  logic poll_i,
    output logic good_o
);
    typedef struct packed {
        logic prev;
        logic seen;
        logic good;
    } watch_t;

    watch_t r_q, r_d;
    logic   rise;

    always_comb begin
        rise       = lvl_i & ~r_q.prev;
        good_o     = r_q.good | (poll_i & (r_q.seen | rise));
        r_d.prev   = lvl_i;
        r_d.seen   = clr_i ? 1'b0 : (r_q.seen | rise);
        r_d.good   = clr_i ? 1'b0 : good_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/rail_bringup_seq.sv
module rail_bringup_seq
    import rail_seq_pkg::*;
#(
    parameter int SETTLE_MS  = 50,
    parameter int POLL_MS    = 40,
    parameter int DL_5V_MS   = 2900,
    parameter int DL_12V_MS  = 2900,
    parameter int DL_8V6_MS  = 6300,
    parameter int MEM_DLY_MS = 2,
    parameter int SYNC_STG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       mains_ok,
    input  logic       det_5v,
    input  logic       det_8v6,
    input  logic       det_12v,
    input  logic       det_core,
    input  logic       prot_in,
    output logic       core_en,
    output logic       mode_a_n,
    output logic       mode_b_n,
    output logic       cpu_rst,
    output logic       audio_en,
    output logic       audio_rst,
    output logic       mem_pwr,
    output logic       ready,
    output logic       prot_stop,
    output logic       err_8v6,
    output logic [1:0] fault_code
);
    localparam int MAX_A  = (DL_5V_MS > DL_12V_MS) ? DL_5V_MS : DL_12V_MS;
    localparam int CAP_MS = (MAX_A > DL_8V6_MS) ? MAX_A : DL_8V6_MS;
    localparam int TW     = $clog2(CAP_MS + 1);
    localparam int MW     = (MEM_DLY_MS > 1) ? $clog2(MEM_DLY_MS + 1) : 1;
    localparam int NSYNC  = NUM_RAILS + 2;
    localparam logic [TW-1:0] DL5_T  = TW'(DL_5V_MS);
    localparam logic [TW-1:0] DL12_T = TW'(DL_12V_MS);
    localparam logic [TW-1:0] DL86_T = TW'(DL_8V6_MS);
    localparam logic [MW-1:0] MEM_T  = MW'(MEM_DLY_MS);

    typedef struct packed {
        seq_st_e       st;
        logic [1:0]    fault;
        logic          err86;
        logic [MW-1:0] md;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [NUM_RAILS-1:0] det_raw, det_s, good;
    logic [NSYNC-1:0]     sync_in, sync_out;
    logic                 mains_s, prot_s;
    logic                 run, clr, step, poll;
    logic [TW-1:0]        ms_next;
    logic                 miss5, miss12, miss86, all_good, in_start;

    // Rail order fixes the index used by the watchers.
    always_comb begin
        det_raw            = '0;
        det_raw[RAIL_5V]   = det_5v;
        det_raw[RAIL_12V]  = det_12v;
        det_raw[RAIL_8V6]  = det_8v6;
        det_raw[RAIL_CORE] = det_core;
    end

    assign sync_in = {prot_in, mains_ok, det_raw};

    rs_sync #(.W(NSYNC), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_in),
        .q_o   (sync_out)
    );

    assign det_s   = sync_out[NUM_RAILS-1:0];
    assign mains_s = sync_out[NUM_RAILS];
    assign prot_s  = sync_out[NUM_RAILS+1];

    assign run = (r_q.st == ST_RAMP) || (r_q.st == ST_MEMW) || (r_q.st == ST_RUN);
    assign clr = (r_q.st == ST_IDLE) || (r_q.st == ST_CORE);

    rs_poll_timer #(
        .SETTLE_MS (SETTLE_MS),
        .POLL_MS   (POLL_MS),
        .CAP_MS    (CAP_MS),
        .TW        (TW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_i    (tick_ms),
        .step_o    (step),
        .ms_next_o (ms_next),
        .poll_o    (poll)
    );

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        rs_rail_watch u_watch (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .lvl_i  (det_s[g]),
            .poll_i (poll),
            .good_o (good[g])
        );
    end

    assign miss5    = step && (ms_next == DL5_T)  && !good[RAIL_5V];
    assign miss12   = step && (ms_next == DL12_T) && !good[RAIL_12V];
    assign miss86   = step && (ms_next == DL86_T) && !good[RAIL_8V6];
    assign all_good = good[RAIL_5V] & good[RAIL_12V] & good[RAIL_CORE];
    assign in_start = (r_q.st == ST_CORE) || (r_q.st == ST_RAMP) || (r_q.st == ST_MEMW);

    always_comb begin
        r_d = r_q;
        if (in_start && prot_s) begin
            r_d.st = ST_PROT;
        end else begin
            unique case (r_q.st)
                ST_IDLE: if (mains_s) r_d.st = ST_CORE;
                ST_CORE: if (tick_ms) r_d.st = ST_RAMP;
                ST_RAMP: begin
                    if (miss5) begin
                        r_d.st    = ST_PROT;
                        r_d.fault = FLT_5V;
                    end else if (miss12) begin
                        r_d.st    = ST_PROT;
                        r_d.fault = FLT_12V;
                    end else if (poll && all_good) begin
                        r_d.st = ST_MEMW;
                        r_d.md = '0;
                    end
                end
                ST_MEMW: begin
                    if (tick_ms) begin
                        if (r_q.md + MW'(1) == MEM_T) r_d.st = ST_RUN;
                        else                          r_d.md = r_q.md + MW'(1);
                    end
                end
                ST_RUN:  r_d.st = ST_RUN;
                ST_PROT: r_d.st = ST_PROT;
                default: r_d.st = ST_PROT;
            endcase
        end
        if (miss86 && (r_d.st != ST_PROT)) begin
            r_d.err86 = 1'b1;
            if (r_d.fault == FLT_NONE) r_d.fault = FLT_8V6;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.fault <= FLT_NONE;
            r_q.err86 <= 1'b0;
            r_q.md    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_en    = (r_q.st != ST_IDLE) && (r_q.st != ST_PROT);
    assign mode_a_n   = !run;
    assign mode_b_n   = !run;
    assign cpu_rst    = !run;
    assign audio_en   = (r_q.st != ST_PROT);
    assign audio_rst  = (r_q.st != ST_PROT);
    assign mem_pwr    = !((r_q.st == ST_MEMW) || (r_q.st == ST_RUN));
    assign ready      = (r_q.st == ST_RUN);
    assign prot_stop  = (r_q.st == ST_PROT);
    assign err_8v6    = r_q.err86;
    assign fault_code = r_q.fault;
endmodule

// File: rtl/rail_bringup_chk.sv
module rail_bringup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms,
    input logic       core_en,
    input logic       mode_a_n,
    input logic       mode_b_n,
    input logic       cpu_rst,
    input logic       audio_en,
    input logic       mem_pwr,
    input logic       ready,
    input logic       prot_stop,
    input logic       err_8v6,
    input logic [1:0] fault_code
);
    // R2
    core_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_a_n) |-> (core_en && $past(core_en) && !mode_b_n && !cpu_rst));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_stop |=> $stable(fault_code));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_8v6 |=> err_8v6);

    // R7
    ready_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mem_pwr && !prot_stop));

    // R8
    ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R9
    prot_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_stop |-> (mode_a_n && mode_b_n && cpu_rst && !core_en && !audio_en && mem_pwr));

    // R9
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_stop |=> prot_stop);

    // R10
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tick_ms));
endmodule

bind rail_bringup_seq rail_bringup_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ms    (tick_ms),
    .core_en    (core_en),
    .mode_a_n   (mode_a_n),
    .mode_b_n   (mode_b_n),
    .cpu_rst    (cpu_rst),
    .audio_en   (audio_en),
    .mem_pwr    (mem_pwr),
    .ready      (ready),
    .prot_stop  (prot_stop),
    .err_8v6    (err_8v6),
    .fault_code (fault_code)
);

// File: tb/rail_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module rail_bringup_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic mains_ok = 1'b0, det_5v = 1'b0, det_8v6 = 1'b0, det_12v = 1'b0;
    logic det_core = 1'b0, prot_in = 1'b0;
    logic core_en, mode_a_n, mode_b_n, cpu_rst, audio_en, audio_rst;
    logic mem_pwr, ready, prot_stop, err_8v6;
    logic [1:0] fault_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 1;
    int tcnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rail_bringup_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .mains_ok(mains_ok),
        .det_5v(det_5v), .det_8v6(det_8v6), .det_12v(det_12v), .det_core(det_core),
        .prot_in(prot_in), .core_en(core_en), .mode_a_n(mode_a_n), .mode_b_n(mode_b_n),
        .cpu_rst(cpu_rst), .audio_en(audio_en), .audio_rst(audio_rst), .mem_pwr(mem_pwr),
        .ready(ready), .prot_stop(prot_stop), .err_8v6(err_8v6), .fault_code(fault_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // tick generator (R10: spacing chosen per test)
    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt    = 0;
            tick_ms = 1'b0;
        end else if (tcnt >= tick_div - 1) begin
            tcnt    = 0;
            tick_ms = 1'b1;
        end else begin
            tcnt    = tcnt + 1;
            tick_ms = 1'b0;
        end
    end

    // ---------------- behavioural reference model ----------------
    // phases: 0 idle, 1 core, 2 ramp, 3 memory wait, 4 running, 5 protection
    int  m_ph, m_fault, m_md, m_el;
    bit  m_err;
    bit  m_s1[6], m_s2[6];
    bit  m_dp[4], m_seen[4], m_ok[4];

    always @(posedge clk) begin
        bit ins[6];
        bit rise[4], gn[4];
        bit run, tk, pl, clr;
        int nel, nph, nf, nmd;
        bit ne;
        if (!rst_n) begin
            m_ph = 0; m_fault = 0; m_md = 0; m_el = 0; m_err = 0;
            for (int k = 0; k < 6; k++) begin m_s1[k] = 0; m_s2[k] = 0; end
            for (int k = 0; k < 4; k++) begin m_dp[k] = 0; m_seen[k] = 0; m_ok[k] = 0; end
        end else begin
            ins[0] = mains_ok; ins[1] = det_5v; ins[2] = det_12v;
            ins[3] = det_8v6;  ins[4] = det_core; ins[5] = prot_in;
            for (int k = 0; k < 4; k++) rise[k] = m_s2[k+1] && !m_dp[k];
            run = (m_ph >= 2 && m_ph <= 4);
            tk  = tick_ms && run && (m_el < 6300);
            nel = m_el + 1;
            pl  = tk && (nel >= 50) && (((nel - 50) % 40) == 0);
            clr = (m_ph <= 1);
            for (int k = 0; k < 4; k++) gn[k] = m_ok[k] || (pl && (m_seen[k] || rise[k]));
            nph = m_ph; nf = m_fault; nmd = m_md; ne = m_err;
            if (m_ph >= 1 && m_ph <= 3 && m_s2[5]) nph = 5;
            else begin
                case (m_ph)
                    0: if (m_s2[0]) nph = 1;
                    1: if (tick_ms) nph = 2;
                    2: begin
                        if (tk && nel == 2900 && !gn[0]) begin nph = 5; nf = 1; end
                        else if (tk && nel == 2900 && !gn[1]) begin nph = 5; nf = 2; end
                        else if (pl && gn[0] && gn[1] && gn[3]) begin nph = 3; nmd = 0; end
                    end
                    3: if (tick_ms) begin
                        if (m_md + 1 == 2) nph = 4; else nmd = m_md + 1;
                    end
                    default: ;
                endcase
            end
            if (tk && nel == 6300 && !gn[2] && nph != 5) begin
                ne = 1;
                if (nf == 0) nf = 3;
            end
            m_el = run ? (tk ? nel : m_el) : 0;
            for (int k = 0; k < 4; k++) begin
                m_seen[k] = clr ? 0 : (m_seen[k] || rise[k]);
                m_ok[k]   = clr ? 0 : gn[k];
                m_dp[k]   = m_s2[k+1];
            end
            for (int k = 0; k < 6; k++) begin m_s2[k] = m_s1[k]; m_s1[k] = ins[k]; end
            m_ph = nph; m_fault = nf; m_md = nmd; m_err = ne;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit on, pr;
        if (!done) begin
            on = (m_ph >= 2 && m_ph <= 4);
            pr = (m_ph == 5);
            chk(mode_a_n == !on && mode_b_n == !on, "R2 mode lines", mode_a_n, !on);
            chk(cpu_rst == !on, "R2 cpu_rst", cpu_rst, !on);
            chk(core_en == (m_ph >= 1 && m_ph <= 4), "R2 core_en", core_en, (m_ph >= 1 && m_ph <= 4));
            chk(audio_en == !pr && audio_rst == !pr, "R9 audio lines", audio_en, !pr);
            chk(mem_pwr == !(m_ph == 3 || m_ph == 4), "R7 mem_pwr", mem_pwr, !(m_ph == 3 || m_ph == 4));
            chk(ready == (m_ph == 4), "R7 ready", ready, (m_ph == 4));
            chk(prot_stop == pr, "R8 prot_stop", prot_stop, pr);
            chk(fault_code == m_fault[1:0], "R5 fault_code", fault_code, m_fault);
            chk(err_8v6 == m_err, "R6 err_8v6", err_8v6, m_err);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n * tick_div) @(negedge clk);
    endtask

    task automatic do_reset(input int div);
        @(negedge clk);
        rst_n = 1'b0;
        mains_ok = 0; det_5v = 0; det_8v6 = 0; det_12v = 0; det_core = 0; prot_in = 0;
        tick_div = div;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        do_reset(1);
        chk(cpu_rst && audio_en && audio_rst && mem_pwr && mode_a_n && mode_b_n,
            "R1 high lines", {cpu_rst, audio_en, audio_rst, mem_pwr, mode_a_n, mode_b_n}, 6'h3f);
        chk(!core_en && !ready && !prot_stop && !err_8v6 && fault_code == 0,
            "R1 low lines", {core_en, ready, prot_stop, err_8v6, fault_code}, 0);

        // normal start-up, then a protection request while running (R7, R8)
        mains_ok = 1;
        wait_ticks(60);  det_core = 1;
        wait_ticks(40);  det_5v = 1;
        wait_ticks(100); det_12v = 1; det_8v6 = 1;
        wait_ticks(150);
        chk(ready == 1, "R7 ready after good rails", ready, 1);
        chk(fault_code == 0, "R7 no fault", fault_code, 0);
        prot_in = 1;
        wait_ticks(10);
        chk(prot_stop == 0 && ready == 1, "R8 ignored when running", prot_stop, 0);
        prot_in = 0;

        // R3: a rise just after a sample point waits for the next one
        do_reset(1);
        det_core = 1'b0;
        mains_ok = 1;
        wait_ticks(5); det_core = 1; det_12v = 1;
        wait_ticks(90); det_5v = 1;
        wait_ticks(10);
        chk(mem_pwr == 1, "R3 no advance between samples", mem_pwr, 1);
        wait_ticks(40);
        chk(mem_pwr == 0, "R3 advance at next sample", mem_pwr, 0);

        // R4, R5, R10: 5 V detect already high, ticks every second cycle
        do_reset(2);
        det_5v = 1;
        wait_ticks(5);
        mains_ok = 1;
        wait_ticks(100); det_core = 1; det_12v = 1; det_8v6 = 1;
        wait_ticks(2900);
        chk(prot_stop == 1, "R4 level without edge does not count", prot_stop, 1);
        chk(fault_code == 1, "R5 5V fault code", fault_code, 1);
        chk(mode_a_n == 1 && core_en == 0, "R9 rails off in protection", {mode_a_n, core_en}, 2'b10);

        // R5: 12 V missing
        do_reset(1);
        mains_ok = 1;
        wait_ticks(80); det_core = 1; det_5v = 1; det_8v6 = 1;
        wait_ticks(2900);
        chk(fault_code == 2, "R5 12V fault code", fault_code, 2);

        // R6: 8.6 V missing is only flagged
        do_reset(1);
        mains_ok = 1;
        wait_ticks(30); det_core = 1; det_5v = 1; det_12v = 1;
        wait_ticks(6400);
        chk(err_8v6 == 1, "R6 flag set", err_8v6, 1);
        chk(fault_code == 3, "R6 code 3", fault_code, 3);
        chk(ready == 1, "R6 still ready", ready, 1);

        // R8, R9: protection request during start-up, then held
        do_reset(1);
        mains_ok = 1;
        wait_ticks(100);
        prot_in = 1;
        wait_ticks(3);
        prot_in = 0;
        chk(prot_stop == 1 && fault_code == 0, "R8 stop during start-up", {prot_stop, fault_code}, 3'b100);
        det_core = 1; det_5v = 1; det_12v = 1; det_8v6 = 1;
        wait_ticks(300);
        chk(prot_stop == 1 && ready == 0, "R9 held until reset", {prot_stop, ready}, 2'b10);
        chk(audio_en == 0 && audio_rst == 0 && cpu_rst == 1, "R9 audio low cpu held",
            {audio_en, audio_rst, cpu_rst}, 3'b001);

        // R7: core rail never confirmed
        do_reset(1);
        mains_ok = 1;
        wait_ticks(40); det_5v = 1; det_12v = 1; det_8v6 = 1;
        wait_ticks(3000);
        chk(mem_pwr == 1 && ready == 0 && prot_stop == 0, "R7 waits for core",
            {mem_pwr, ready, prot_stop}, 3'b100);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule